// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on a two-wire serial bus: one clock line and one open-drain data line, at bus rates up to 400 kbit/s. It answers to a fixed 7-bit device address. A transaction first loads an internal register pointer. After that the master either writes one data byte to the pointed register, or issues a repeated START and reads one byte back from that register. The block never drives the data line high. It only pulls the line low through an output-enable, and the pad turns that enable into an open-drain driver.

Both bus lines are sampled in a fast system clock domain. Each line passes through a two-flop synchroniser and then a three-sample majority vote. START, STOP and the clock edges are detected only after that filtering. On the register side there is a plain port: a register address, a one-cycle write strobe with write data, and combinational read data with a hit flag from the register file. When the register file reports no hit, the block returns an all-ones byte.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_oe` is 0 and `reg_wr_en` is 0; `reg_addr` is 0x00 until a pointer byte has been received.
- R2: A first byte whose upper seven bits equal the device address 1001000 (0x90 for a write, 0x91 for a read) is acknowledged: the slave holds SDA low during the ninth clock's high phase. `sda_oe` changes only while the filtered SCL is low.
- R3: A first byte with any other address is not acknowledged. The slave then leaves SDA alone and issues no write until the next START or STOP.
- R4: In a write, the pointer byte and the data byte are each acknowledged. After the data byte, `reg_wr_en` pulses for exactly one cycle with `reg_addr` equal to the pointer and `reg_wr_data` equal to the data byte. Bytes are sent MSB first.
- R5: In a read (START, 0x90, pointer, repeated START, 0x91), the 0x91 byte is acknowledged. The slave then shifts out `reg_rd_data` of the pointed register MSB first, one bit per SCL period.
- R6: When `reg_rd_hit` is 0 for the pointed register, the byte returned is 0xFF.
- R7: Access is single-byte. A byte that follows an acknowledged write data byte is not acknowledged and produces no write.
- R8: After the eighth read bit, the slave releases SDA for the master's acknowledge bit, whether that bit is ACK or NACK, and goes idle. A following transaction works normally.
- R9: A START or STOP anywhere restarts or aborts the transaction. A STOP or repeated START in the middle of a data byte produces no write, and the pointer that was received is kept for a following read.
- R10: A one-system-clock pulse on SDA during SCL high is filtered out. It is not taken as a START or STOP, and the byte being received is not corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Data byte for the write |
| reg_rd_data | input | 8 | Contents of the register at `reg_addr` |
| reg_rd_hit | input | 1 | 1 if `reg_addr` names an existing register |

## Verification
A state machine in the wrong state shows up at the bus as a missing or extra acknowledge within the same byte. It can also show up on the register side as a write strobe that is lost, repeated, or sent to the wrong pointer, seen right after the data byte's acknowledge clock. A bit counter that is off by one shifts every returned read bit, so the first read in the run catches it. A filter or edge detector that passes a short pulse turns a plain data bit into a false START/STOP, and the write in flight disappears. All of these are visible within one transaction.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] UNMAPPED_FILL = '1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } slv_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/i2cs_deglitch.sv
`timescale 1ns/1ps
module i2cs_deglitch #(
    parameter int LANES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);
    import i2cs_pkg::*;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SYNC_STAGES-1:0] sync_q;
        logic [2:0]             hist_q;
        logic                   vote_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '1;
                hist_q <= '1;
                vote_q <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], d[l]};
                hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
                vote_q <= maj3(hist_q);
            end
        end

        assign q[l] = vote_q;
    end

endmodule

// File: rtl/i2cs_bus_events.sv
`timescale 1ns/1ps
module i2cs_bus_events (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    output i2cs_pkg::bus_ev_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    always_comb begin
        ev.start = scl & scl_d & sda_d & ~sda;
        ev.stop  = scl & scl_d & ~sda_d & sda;
        ev.rise  = scl & ~scl_d;
        ev.fall  = ~scl & scl_d;
    end

endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine #(
    parameter logic [6:0] DEV_ADDR = 7'b1001000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  i2cs_pkg::bus_ev_t           ev,
    input  logic                        sda,
    input  logic [i2cs_pkg::BYTE_W-1:0] rd_data,
    input  logic                        rd_hit,
    output logic                        sda_oe,
    output logic [i2cs_pkg::BYTE_W-1:0] ptr,
    output logic                        wr_en,
    output logic [i2cs_pkg::BYTE_W-1:0] wr_data,
    output i2cs_pkg::slv_state_t        state
);
    import i2cs_pkg::*;

    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-1:0]    sh;
    logic                 got_byte;
    logic                 rw_read;
    logic                 rx_state;
    logic [BYTE_W-1:0]    rd_byte;

    assign rx_state = (state == ST_DEV) || (state == ST_PTR) || (state == ST_WDATA);
    assign rd_byte  = rd_hit ? rd_data : UNMAPPED_FILL;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            got_byte <= 1'b0;
            rw_read  <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state    <= ST_DEV;
                cnt      <= '0;
                got_byte <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                got_byte <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                if (ev.rise && rx_state) begin
                    sh  <= {sh[BYTE_W-2:0], sda};
                    cnt <= cnt + 1'b1;
                    if (cnt == BIT_CNT_W'(BYTE_W-1)) got_byte <= 1'b1;
                end
                if (ev.fall) begin
                    case (state)
                        ST_DEV: if (got_byte) begin
                            got_byte <= 1'b0;
                            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                                state   <= ST_DEV_ACK;
                                sda_oe  <= 1'b1;
                                rw_read <= sh[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_PTR: if (got_byte) begin
                            got_byte <= 1'b0;
                            ptr      <= sh;
                            state    <= ST_PTR_ACK;
                            sda_oe   <= 1'b1;
                        end
                        ST_WDATA: if (got_byte) begin
                            got_byte <= 1'b0;
                            wr_en    <= 1'b1;
                            wr_data  <= sh;
                            state    <= ST_WDATA_ACK;
                            sda_oe   <= 1'b1;
                        end
                        ST_DEV_ACK: begin
                            cnt <= '0;
                            if (rw_read) begin
                                state  <= ST_RDATA;
                                sh     <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                            end else begin
                                state  <= ST_PTR;
                                sda_oe <= 1'b0;
                            end
                        end
                        ST_PTR_ACK: begin
                            state  <= ST_WDATA;
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                        end
                        ST_WDATA_ACK: begin
                            state  <= ST_IGNORE;
                            sda_oe <= 1'b0;
                        end
                        ST_RDATA: begin
                            if (cnt == BIT_CNT_W'(BYTE_W-1)) begin
                                state  <= ST_RDATA_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                cnt    <= cnt + 1'b1;
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                            end
                        end
                        ST_RDATA_ACK: state <= ST_IDLE;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
`timescale 1ns/1ps
module i2c_reg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b1001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic       reg_wr_en,
    output logic [7:0] reg_wr_data,
    input  logic [7:0] reg_rd_data,
    input  logic       reg_rd_hit
);
    import i2cs_pkg::*;

    logic [1:0] lines_f;
    logic       scl_f, sda_f;
    bus_ev_t    ev;
    slv_state_t eng_state;

    i2cs_deglitch #(.LANES(2), .SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines_f)
    );

    assign scl_f = lines_f[1];
    assign sda_f = lines_f[0];

    i2cs_bus_events u_events (
        .clk (clk),
        .rst (rst),
        .scl (scl_f),
        .sda (sda_f),
        .ev  (ev)
    );

    i2cs_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .sda     (sda_f),
        .rd_data (reg_rd_data),
        .rd_hit  (reg_rd_hit),
        .sda_oe  (sda_oe),
        .ptr     (reg_addr),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .state   (eng_state)
    );

endmodule

// File: rtl/i2cs_checker.sv
`timescale 1ns/1ps
module i2cs_checker (
    input logic                 clk,
    input logic                 rst,
    input logic                 scl_f,
    input logic                 sda_oe,
    input logic                 reg_wr_en,
    input logic [7:0]           reg_addr,
    input i2cs_pkg::slv_state_t eng_state
);
    import i2cs_pkg::*;

    // R1
    oe_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe);

    // R2
    oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_f));

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ST_IGNORE) |-> !sda_oe);

    // R4
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R4
    wr_addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> $stable(reg_addr));

endmodule

bind i2c_reg_slave i2cs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .eng_state (eng_state)
);

// File: tb/i2c_reg_slave_bench.sv
`timescale 1ns/1ps
module i2c_reg_slave_bench;

    localparam int Q = 16;
    localparam int NVEC = 10;
    // {is_read, register, write data or expected read data}
    localparam logic [16:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'h03, 8'h5A},
        {1'b1, 8'h03, 8'h5A},
        {1'b0, 8'h11, 8'hC3},
        {1'b1, 8'h11, 8'hC3},
        {1'b1, 8'h00, 8'h00},
        {1'b1, 8'h0B, 8'hFF},
        {1'b0, 8'h0B, 8'h12},
        {1'b1, 8'h0B, 8'hFF},
        {1'b0, 8'h00, 8'h81},
        {1'b1, 8'h00, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic       reg_rd_hit;
    logic       bus_sda;

    int nchk = 0;
    int nfail = 0;
    int wr_cnt = 0;
    logic [7:0] last_wa = '0;
    logic [7:0] last_wd = '0;
    logic [7:0] rf [0:31];

    always #4 clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;

    function automatic logic is_hit(input logic [7:0] a);
        return (a <= 8'h11) && !(a >= 8'h0B && a <= 8'h0F && a != 8'h0C);
    endfunction

    assign reg_rd_data = rf[reg_addr[4:0]];
    assign reg_rd_hit  = is_hit(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) rf[i] <= '0;
            wr_cnt <= 0;
        end else if (reg_wr_en) begin
            wr_cnt  <= wr_cnt + 1;
            last_wa <= reg_addr;
            last_wd <= reg_wr_data;
            if (is_hit(reg_addr)) rf[reg_addr[4:0]] <= reg_wr_data;
        end
    end

    i2c_reg_slave u_i2c_reg_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (bus_sda),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .reg_rd_hit  (reg_rd_hit)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_start();
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
    endtask

    task automatic do_stop();
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        scl_m = 1'b0; tick(Q);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        if (glitch) begin
            sda_m = 1'b0; tick(1);
            sda_m = b;
        end
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i], i == glitch_bit);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = (bus_sda == 1'b0);
        tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b, output logic released);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; tick(Q);
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = bus_sda;
            tick(Q);
        end
        scl_m = 1'b0; tick(Q);
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(Q);
        released = ~sda_oe;
        tick(Q);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int glitch_bit,
                            input string req);
        logic ack;
        int   c0;
        do_start();
        send_byte(8'h90, -1, ack);
        chk(ack, "R2", "device address ack", ack, 1);
        send_byte(a, -1, ack);
        chk(ack, "R4", "pointer ack", ack, 1);
        c0 = wr_cnt;
        send_byte(d, glitch_bit, ack);
        chk(ack, req, "write data ack", ack, 1);
        do_stop();
        chk(wr_cnt == c0 + 1, req, "write strobe count", wr_cnt - c0, 1);
        chk(last_wa == a && last_wd == d, req, "write addr/data",
            {last_wa, last_wd}, {a, d});
    endtask

    task automatic do_read(input logic [7:0] a, input logic mack, output logic [7:0] v);
        logic ack, rel;
        do_start();
        send_byte(8'h90, -1, ack);
        chk(ack, "R2", "device address ack (read)", ack, 1);
        send_byte(a, -1, ack);
        chk(ack, "R5", "pointer ack (read)", ack, 1);
        do_start();
        send_byte(8'h91, -1, ack);
        chk(ack, "R5", "read address ack", ack, 1);
        recv_byte(mack, v, rel);
        chk(rel, "R8", "SDA released in master ack bit", rel, 1);
        do_stop();
    endtask

    initial begin
        logic [7:0] v;
        logic       ack;
        int         c0;

        tick(10);
        // R1: reset state
        chk(sda_oe == 1'b0 && reg_wr_en == 1'b0, "R1", "outputs in reset",
            {sda_oe, reg_wr_en}, 0);
        rst = 1'b0;
        tick(1);
        chk(sda_oe == 1'b0 && reg_wr_en == 1'b0 && reg_addr == 8'h00, "R1",
            "outputs after reset", {sda_oe, reg_wr_en, reg_addr}, 0);
        tick(20);

        // Vector table: R4 writes, R5 reads, R6 unmapped
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][16]) begin
                do_read(VEC[k][15:8], 1'b0, v);
                chk(v == VEC[k][7:0], is_hit(VEC[k][15:8]) ? "R5" : "R6",
                    "read byte", v, VEC[k][7:0]);
            end else begin
                do_write(VEC[k][15:8], VEC[k][7:0], -1, "R4");
            end
        end

        // R3: wrong device address, bus ignored
        c0 = wr_cnt;
        do_start();
        send_byte(8'hA0, -1, ack);
        chk(!ack, "R3", "foreign address not acked", ack, 0);
        send_byte(8'h03, -1, ack);
        chk(!ack, "R3", "later byte not acked", ack, 0);
        send_byte(8'h77, -1, ack);
        do_stop();
        chk(wr_cnt == c0, "R3", "no write for foreign address", wr_cnt - c0, 0);
        do_read(8'h03, 1'b0, v);
        chk(v == 8'h5A, "R3", "register untouched", v, 8'h5A);

        // R7: extra byte after write data
        c0 = wr_cnt;
        do_start();
        send_byte(8'h90, -1, ack);
        send_byte(8'h05, -1, ack);
        send_byte(8'h11, -1, ack);
        chk(ack, "R7", "first data acked", ack, 1);
        send_byte(8'h22, -1, ack);
        chk(!ack, "R7", "second data not acked", ack, 0);
        do_stop();
        chk(wr_cnt == c0 + 1, "R7", "single write only", wr_cnt - c0, 1);
        do_read(8'h05, 1'b0, v);
        chk(v == 8'h11, "R7", "register holds first byte", v, 8'h11);

        // R8: master ACK after read byte, then a new transaction
        do_read(8'h05, 1'b1, v);
        chk(v == 8'h11, "R8", "read with master ack", v, 8'h11);
        chk(sda_oe == 1'b0, "R8", "idle after read", sda_oe, 0);
        do_write(8'h06, 8'h66, -1, "R8");
        do_read(8'h06, 1'b0, v);
        chk(v == 8'h66, "R8", "write after acked read", v, 8'h66);

        // R9: STOP inside a data byte aborts the write
        c0 = wr_cnt;
        do_start();
        send_byte(8'h90, -1, ack);
        send_byte(8'h07, -1, ack);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        do_stop();
        chk(wr_cnt == c0, "R9", "stop mid byte gives no write", wr_cnt - c0, 0);

        // R9: repeated START inside a data byte keeps the pointer
        do_write(8'h08, 8'h3C, -1, "R4");
        c0 = wr_cnt;
        do_start();
        send_byte(8'h90, -1, ack);
        send_byte(8'h08, -1, ack);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        do_start();
        send_byte(8'h91, -1, ack);
        chk(ack, "R9", "read address ack after restart", ack, 1);
        recv_byte(1'b0, v, ack);
        do_stop();
        chk(v == 8'h3C, "R9", "read after restart", v, 8'h3C);
        chk(wr_cnt == c0, "R9", "restart mid byte gives no write", wr_cnt - c0, 0);

        // R10: one-cycle SDA pulse during SCL high is filtered
        do_write(8'h09, 8'hFF, 4, "R10");
        do_read(8'h09, 1'b0, v);
        chk(v == 8'hFF, "R10", "glitched byte stored intact", v, 8'hFF);

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule